// File: doc/BRIEF.md
# Hardware Breakpoint and Watchpoint Matcher

This block watches a processor's instruction fetches and data accesses and raises a break event when one of them hits a programmed comparator. It holds four instruction comparators, each an address register with its own enable, and two data watch channels. Each data channel covers one aligned 8-byte block. It has a per-byte ignore mask and an access-type field that selects writes, reads or both.

Every hit sets a sticky bit in a cause register, with one bit per comparator. The event output pulses for one cycle, in the cycle after the access that hit. Software clears the cause by writing zero to it. A debug-mode input suppresses all detection, so the debug handler's own fetches and accesses never re-trigger the block.

The fetch and data access inputs are observation-only strobes. The block samples them whenever their valid bit is high and never stalls the source, so there is no ready signal and no back-pressure. The configuration path is a plain one-cycle write strobe with a register select and 32-bit data.

Top module: `brkwatch_unit`

## Requirements
- R1: After reset, `brk_event` is 0, the cause register is 0, all comparators are disabled and every mask byte is 0x00.
- R2: Instruction comparator i hits when `fetch_valid` is 1, its enable bit is 1 and its address register equals `fetch_addr`. A disabled comparator never hits. Cause bit i (bits 3..0) records the hit.
- R3: Data channel c hits only when `data_addr[31:3]` equals bits 31:3 of its address register and the access touches at least one watched byte of that block. Cause bit 4+c records the hit.
- R4: `data_size` encodes 0, 1, 2 and 3 as 1, 2, 4 and 8 bytes. The lanes touched run from byte `data_addr[2:0]` upward for that many bytes and stop at byte 7. Lanes past the end of the block are dropped.
- R5: A byte k of a channel's block is ignored when its mask byte is 0xFF and watched otherwise. Bytes 0..3 sit in the high mask word at bits 31:24 down to 7:0, and bytes 4..7 sit the same way in the low mask word.
- R6: Each channel's 3-bit access-type field works as follows: bit 1 permits writes and bit 2 permits reads. So 2 means writes only, 4 means reads only, 6 means any access, and 0 disables the channel.
- R7: Register selects are: 0..3 for the instruction addresses; 4 for control; 5, 6 and 7 for channel 0's address, high mask and low mask; 8, 9 and 10 for the same three on channel 1; and 11 for the cause register. Control bits 3:0 are the instruction enables, bits 6:4 are channel 0's type and bits 10:8 are channel 1's type.
- R8: The low three bits written to a channel address register have no effect on matching.
- R9: `brk_event` is 1 in exactly the cycle after an access that hit at least one comparator, and 0 otherwise.
- R10: Cause bits are sticky and OR together across hits. Writing zero to select 11 clears them. Writing a nonzero value there leaves them unchanged. A hit in the same cycle as a clear remains set afterwards.
- R11: While `debug_mode` is 1, no comparator hits: no event follows and no cause bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| debug_mode | input | 1 | Suppresses all detection while high |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 32 | Instruction fetch address |
| data_valid | input | 1 | Data access strobe |
| data_addr | input | 32 | Data access byte address |
| data_size | input | 2 | Access size code (1/2/4/8 bytes) |
| data_write | input | 1 | 1 for a write, 0 for a read |
| brk_event | output | 1 | One-cycle break pulse |
| cause | output | 6 | Sticky cause bits: [3:0] instruction, [5:4] data channels |

## Verification
The bench targets lane arithmetic at the block edge. An 8-byte access starting at byte 7 must see only lane 7. A design that wraps lanes or checks the next block would hit on a watched byte 0 or 5 when it should not. A 4-byte access starting at byte 2 must reach the watched byte 5; a design with an off-by-one lane range would miss it.

Access-type decoding is driven with reads against a write-only channel and with type 0. A design that swaps the two type bits fires on the wrong direction.

The clear-versus-hit collision checks that a design letting the clear win does not lose the new cause. A nonzero write to the cause register checks that a design does not treat any write as a clear. Debug-mode fetches on enabled addresses catch a design that gates only the event and still sets the cause.

// File: rtl/brkwatch_pkg.sv
package brkwatch_pkg;
  // Access-type field layout inside the control register
  localparam int TYPE_W      = 3;
  localparam int TYPE_WR_BIT = 1;
  localparam int TYPE_RD_BIT = 2;
  localparam int CH_STRIDE   = 4;
  localparam int BLK_BYTES   = 8;
  localparam int OFF_W       = $clog2(BLK_BYTES);
  localparam int CFG_W       = 32;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/brkwatch_icmp.sv
module brkwatch_icmp #(
  parameter int ADDR_W = 32
) (
  input  logic              fetch_ok,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic              bp_en,
  output logic              hit
);
  always_comb hit = fetch_ok && bp_en && (bp_addr == fetch_addr);
endmodule

// File: rtl/brkwatch_dcmp.sv
module brkwatch_dcmp
  import brkwatch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                    acc_ok,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [1:0]              acc_size,
  input  logic                    acc_write,
  input  logic [ADDR_W-OFF_W-1:0] ch_blk,
  input  logic [8*BLK_BYTES-1:0]  ch_mask,
  input  logic [TYPE_W-1:0]       ch_type,
  output logic                    hit
);
  logic [BLK_BYTES-1:0] run;
  logic [BLK_BYTES-1:0] lanes;
  logic [BLK_BYTES-1:0] watched;
  logic                 dir_ok;
  logic                 blk_eq;

  // Contiguous run of ones, one per byte of the access
  always_comb begin
    unique case (acc_size_e'(acc_size))
      SZ_B1:   run = 8'h01;
      SZ_B2:   run = 8'h03;
      SZ_B4:   run = 8'h0F;
      default: run = 8'hFF;
    endcase
  end

  // Shift within the block; lanes past byte 7 fall off the top
  assign lanes = run << acc_addr[OFF_W-1:0];

  // Byte k of the block lives at mask bits [63-8k -: 8] (big-endian)
  for (genvar k = 0; k < BLK_BYTES; k++) begin : g_lane
    assign watched[k] = (ch_mask[8*BLK_BYTES-1-8*k -: 8] != 8'hFF);
  end

  assign dir_ok = acc_write ? ch_type[TYPE_WR_BIT] : ch_type[TYPE_RD_BIT];
  assign blk_eq = (acc_addr[ADDR_W-1:OFF_W] == ch_blk);
  assign hit    = acc_ok && blk_eq && dir_ok && (|(lanes & watched));
endmodule

// File: rtl/brkwatch_regs.sv
module brkwatch_regs
  import brkwatch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_IBRK = 4,
  parameter int N_DCH  = 2,
  parameter int SEL_W  = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cfg_we,
  input  logic [SEL_W-1:0]                         cfg_sel,
  input  logic [CFG_W-1:0]                         cfg_wdata,
  input  logic [N_IBRK+N_DCH-1:0]                  hits,
  output logic [N_IBRK-1:0][ADDR_W-1:0]            ib_addr,
  output logic [N_IBRK-1:0]                        ib_en,
  output logic [N_DCH-1:0][ADDR_W-OFF_W-1:0]       ch_blk,
  output logic [N_DCH-1:0][8*BLK_BYTES-1:0]        ch_mask,
  output logic [N_DCH-1:0][TYPE_W-1:0]             ch_type,
  output logic [N_IBRK+N_DCH-1:0]                  cause
);
  localparam int NC        = N_IBRK + N_DCH;
  localparam int SEL_CTRL  = N_IBRK;
  localparam int SEL_CH0   = N_IBRK + 1;
  localparam int SEL_CAUSE = N_IBRK + 1 + 3 * N_DCH;

  logic clr_wr;
  assign clr_wr = cfg_we && (cfg_sel == SEL_W'(SEL_CAUSE)) && (cfg_wdata == '0);

  // Instruction comparator addresses
  for (genvar i = 0; i < N_IBRK; i++) begin : g_ib
    always_ff @(posedge clk) begin
      if (!rst_n) ib_addr[i] <= '0;
      else if (cfg_we && cfg_sel == SEL_W'(i)) ib_addr[i] <= cfg_wdata[ADDR_W-1:0];
    end
  end

  // Control: enables plus one access-type field per channel
  always_ff @(posedge clk) begin
    if (!rst_n) ib_en <= '0;
    else if (cfg_we && cfg_sel == SEL_W'(SEL_CTRL)) ib_en <= cfg_wdata[N_IBRK-1:0];
  end

  for (genvar c = 0; c < N_DCH; c++) begin : g_ch
    localparam int S_ADDR = SEL_CH0 + 3 * c;
    localparam int T_POS  = N_IBRK + CH_STRIDE * c;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ch_type[c] <= '0;
        ch_blk[c]  <= '0;
        ch_mask[c] <= '0;
      end else if (cfg_we) begin
        if (cfg_sel == SEL_W'(SEL_CTRL))   ch_type[c] <= cfg_wdata[T_POS +: TYPE_W];
        if (cfg_sel == SEL_W'(S_ADDR))     ch_blk[c]  <= cfg_wdata[ADDR_W-1:OFF_W];
        if (cfg_sel == SEL_W'(S_ADDR + 1)) ch_mask[c][8*BLK_BYTES-1 -: CFG_W] <= cfg_wdata;
        if (cfg_sel == SEL_W'(S_ADDR + 2)) ch_mask[c][CFG_W-1:0] <= cfg_wdata;
      end
    end
  end

  // Sticky cause: a hit in the clearing cycle survives the clear
  always_ff @(posedge clk) begin
    if (!rst_n) cause <= '0;
    else        cause <= (clr_wr ? '0 : cause) | hits;
  end

  // R10: clearing with no concurrent hit empties the cause register
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && hits == '0) |=> (cause == '0));

  // R10: without a clear, no cause bit ever drops
  a_r10_sticky_bits: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (($past(cause) & ~cause) == '0));

  // R2: a disabled instruction comparator never records a cause
  a_r2_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == '0 && !clr_wr && ib_en == '0 && ch_type == '0) |=> (cause == '0));

  initial begin
    if (NC > CFG_W) $error("cause register too wide");
  end
endmodule

// File: rtl/brkwatch_unit.sv
module brkwatch_unit
  import brkwatch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_IBRK = 4,
  parameter int N_DCH  = 2,
  localparam int NC     = N_IBRK + N_DCH,
  localparam int N_REGS = N_IBRK + 1 + 3 * N_DCH + 1,
  localparam int SEL_W  = $clog2(N_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              debug_mode,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              data_valid,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic [1:0]        data_size,
  input  logic              data_write,
  output logic              brk_event,
  output logic [NC-1:0]     cause
);
  logic [N_IBRK-1:0][ADDR_W-1:0]      ib_addr;
  logic [N_IBRK-1:0]                  ib_en;
  logic [N_DCH-1:0][ADDR_W-OFF_W-1:0] ch_blk;
  logic [N_DCH-1:0][8*BLK_BYTES-1:0]  ch_mask;
  logic [N_DCH-1:0][TYPE_W-1:0]       ch_type;
  logic [NC-1:0]                      hits;
  logic                               fetch_ok;
  logic                               acc_ok;

  assign fetch_ok = fetch_valid && !debug_mode;
  assign acc_ok   = data_valid && !debug_mode;

  brkwatch_regs #(
    .ADDR_W(ADDR_W), .N_IBRK(N_IBRK), .N_DCH(N_DCH), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .hits(hits),
    .ib_addr(ib_addr), .ib_en(ib_en),
    .ch_blk(ch_blk), .ch_mask(ch_mask), .ch_type(ch_type),
    .cause(cause)
  );

  for (genvar i = 0; i < N_IBRK; i++) begin : g_icmp
    brkwatch_icmp #(.ADDR_W(ADDR_W)) u_icmp (
      .fetch_ok(fetch_ok), .fetch_addr(fetch_addr),
      .bp_addr(ib_addr[i]), .bp_en(ib_en[i]),
      .hit(hits[i])
    );
  end

  for (genvar c = 0; c < N_DCH; c++) begin : g_dcmp
    brkwatch_dcmp #(.ADDR_W(ADDR_W)) u_dcmp (
      .acc_ok(acc_ok), .acc_addr(data_addr), .acc_size(data_size),
      .acc_write(data_write), .ch_blk(ch_blk[c]), .ch_mask(ch_mask[c]),
      .ch_type(ch_type[c]), .hit(hits[N_IBRK + c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) brk_event <= 1'b0;
    else        brk_event <= |hits;
  end

  // R9: an event always leaves a cause bit behind
  a_r9_event_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    brk_event |-> (cause != '0));

  // R9: an event follows only a cycle that carried an access
  a_r9_event_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    brk_event |-> $past(fetch_valid || data_valid));

  // R11: nothing fires after a debug-mode cycle
  a_r11_debug_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(debug_mode) |-> !brk_event);
endmodule

// File: tb/brkwatch_unit_bench.sv
module brkwatch_unit_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        debug_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        data_valid = 1'b0;
  logic [31:0] data_addr = '0;
  logic [1:0]  data_size = '0;
  logic        data_write = 1'b0;
  logic        brk_event;
  logic [5:0]  cause;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Bench model of the programmed state
  logic [31:0] m_ib [4];
  logic [3:0]  m_en;
  logic [2:0]  m_ty [2];
  logic [31:0] m_ca [2];
  logic [31:0] m_mh [2];
  logic [31:0] m_ml [2];
  logic [5:0]  m_cause;

  always #5 clk = ~clk;

  brkwatch_unit u_brkwatch_unit (
    .clk(clk), .rst_n(rst_n), .debug_mode(debug_mode),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .data_valid(data_valid), .data_addr(data_addr),
    .data_size(data_size), .data_write(data_write),
    .brk_event(brk_event), .cause(cause)
  );

  function automatic logic [5:0] exp_hits(bit fv, logic [31:0] fa, bit dv,
      logic [31:0] da, logic [1:0] dsz, bit dw, bit dbg);
    logic [5:0] h = '0;
    int nb = 1 << dsz;
    int off = da[2:0];
    if (dbg) return '0;                                   // R11
    for (int i = 0; i < 4; i++)                           // R2
      if (fv && m_en[i] && m_ib[i] == fa) h[i] = 1'b1;
    for (int c = 0; c < 2; c++) begin                     // R3..R6, R8
      bit ok = dw ? m_ty[c][1] : m_ty[c][2];
      logic [63:0] mk = {m_mh[c], m_ml[c]};
      if (dv && ok && da[31:3] == m_ca[c][31:3])
        for (int k = 0; k < 8; k++)
          if (k >= off && k < off + nb && mk[63-8*k -: 8] != 8'hFF) h[4+c] = 1'b1;
    end
    return h;
  endfunction

  task automatic step(bit fv, logic [31:0] fa, bit dv, logic [31:0] da,
      logic [1:0] dsz, bit dw, bit dbg, bit we, logic [3:0] sel,
      logic [31:0] wd, string tag);
    logic [5:0] h;
    bit ev_exp;
    fetch_valid = fv; fetch_addr = fa; data_valid = dv; data_addr = da;
    data_size = dsz; data_write = dw; debug_mode = dbg;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    h = exp_hits(fv, fa, dv, da, dsz, dw, dbg);
    ev_exp = |h;
    m_cause = ((we && sel == 4'd11 && wd == 0) ? 6'd0 : m_cause) | h;
    if (we) begin                                          // R7 map
      case (sel)
        4'd0, 4'd1, 4'd2, 4'd3: m_ib[sel] = wd;
        4'd4: begin m_en = wd[3:0]; m_ty[0] = wd[6:4]; m_ty[1] = wd[10:8]; end
        4'd5: m_ca[0] = wd;
        4'd6: m_mh[0] = wd;
        4'd7: m_ml[0] = wd;
        4'd8: m_ca[1] = wd;
        4'd9: m_mh[1] = wd;
        4'd10: m_ml[1] = wd;
        default: ;
      endcase
    end
    @(negedge clk);
    checks++;
    if (brk_event !== ev_exp || cause !== m_cause) begin
      errors++;
      $display("FAIL %s: event=%0b cause=%02h expected event=%0b cause=%02h",
               tag, brk_event, cause, ev_exp, m_cause);
    end
  endtask

  task automatic wr(logic [3:0] sel, logic [31:0] wd, string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, sel, wd, tag);
  endtask
  task automatic fetch(logic [31:0] fa, bit dbg, string tag);
    step(1, fa, 0, 0, 0, 0, dbg, 0, 0, 0, tag);
  endtask
  task automatic dacc(logic [31:0] da, logic [1:0] dsz, bit dw, string tag);
    step(0, 0, 1, da, dsz, dw, 0, 0, 0, 0, tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0B7A));
    for (int i = 0; i < 4; i++) m_ib[i] = '0;
    for (int c = 0; c < 2; c++) begin m_ty[c] = '0; m_ca[c] = '0; m_mh[c] = '0; m_ml[c] = '0; end
    m_en = '0; m_cause = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (brk_event !== 1'b0 || cause !== 6'd0) begin
      errors++;
      $display("FAIL R1 reset: event=%0b cause=%02h expected 0 00", brk_event, cause);
    end
    // R1: reset masks are all watched but every channel type is 0
    dacc(32'h0000_0000, 2'd3, 1, "R1 idle channel");

    wr(4'd0, 32'h0000_1000, "R7 ib0");
    wr(4'd1, 32'h0000_2004, "R7 ib1");
    wr(4'd2, 32'h0000_3008, "R7 ib2");
    wr(4'd3, 32'h0000_400C, "R7 ib3");
    wr(4'd5, 32'h0000_8005, "R8 ch0 addr low bits");
    wr(4'd6, 32'hFFFF_FFFF, "R5 ch0 mask hi");
    wr(4'd7, 32'hFF00_FFFF, "R5 ch0 mask lo");
    wr(4'd8, 32'h0000_9010, "R7 ch1 addr");
    wr(4'd9, 32'h0000_0000, "R7 ch1 mask hi");
    wr(4'd10, 32'h0000_0000, "R7 ch1 mask lo");
    wr(4'd4, 32'h0000_0427, "R7 ctrl");

    fetch(32'h0000_2004, 0, "R2 ib1 hit");
    fetch(32'h0000_400C, 0, "R2 disabled ib3");
    fetch(32'h0000_1004, 0, "R2 near miss");
    wr(4'd11, 32'h0, "R10 clear");
    dacc(32'h0000_8005, 2'd0, 1, "R3 watched byte 5");
    wr(4'd11, 32'h0, "R10 clear");
    dacc(32'h0000_8004, 2'd0, 1, "R5 ignored byte 4");
    dacc(32'h0000_8004, 2'd1, 1, "R4 halfword covers 5");
    dacc(32'h0000_8005, 2'd0, 0, "R6 read on write-only");
    wr(4'd11, 32'h0, "R10 clear");
    dacc(32'h0000_8007, 2'd3, 1, "R4 crossing keeps lane 7 only");
    dacc(32'h0000_8002, 2'd2, 1, "R4 word lanes 2..5");
    dacc(32'h0000_8805, 2'd0, 1, "R3 other block");
    dacc(32'h0000_9017, 2'd0, 0, "R6 ch1 read");
    dacc(32'h0000_9017, 2'd0, 1, "R6 ch1 write ignored");
    fetch(32'h0000_1000, 1, "R11 debug fetch");
    step(0, 0, 1, 32'h0000_9010, 2'd3, 0, 1, 0, 0, 0, "R11 debug access");
    wr(4'd11, 32'h0000_003F, "R10 nonzero write ignored");
    step(1, 32'h0000_1000, 0, 0, 0, 0, 0, 1, 4'd11, 32'h0, "R10 hit beats clear");
    step(1, 32'h0000_3008, 1, 32'h0000_9010, 2'd3, 0, 0, 0, 0, 0, "R10 or of two hits");
    wr(4'd4, 32'h0000_0467, "R6 type any");
    dacc(32'h0000_8005, 2'd0, 0, "R6 any read");
    wr(4'd4, 32'h0000_0407, "R6 type off");
    dacc(32'h0000_8005, 2'd0, 1, "R6 disabled channel");
    dacc(32'h0000_8005, 2'd0, 1, "R9 event low after miss");

    // Constrained random traffic around the programmed addresses
    for (int n = 0; n < 600; n++) begin
      int op = $urandom % 12;
      if (op == 0) begin
        int s = $urandom % 11;
        logic [31:0] d;
        if (s <= 3) d = 32'h1000 + ($urandom % 8) * 4;
        else if (s == 4) d = $urandom;
        else if (s == 5 || s == 8) d = 32'h8000 + ($urandom % 4) * 8 + ($urandom % 8);
        else begin
          int pick = $urandom % 3;
          d = (pick == 0) ? 32'h0 : (pick == 1) ? 32'hFFFF_FFFF : $urandom;
          for (int b = 0; b < 4; b++) if ($urandom % 2) d[8*b +: 8] = 8'hFF;
        end
        wr(4'(s), d, "R7/R10 random write");
      end else if (op == 1) begin
        wr(4'd11, ($urandom % 3 == 0) ? $urandom : 32'h0, "R10 random clear");
      end else begin
        bit fv = ($urandom % 2) == 1;
        logic [31:0] fa = ($urandom % 3 == 0) ? 32'h1000 + ($urandom % 8) * 4 : m_ib[$urandom % 4];
        bit dv = ($urandom % 2) == 1;
        logic [31:0] da = 32'h8000 + ($urandom % 40);
        step(fv, fa, dv, da, 2'($urandom % 4), ($urandom % 2) == 1,
             ($urandom % 8) == 0, 0, 0, 0, "R2/R3/R4/R5/R6/R9/R11 random");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule